// File: doc/BRIEF.md
# Interrupt Control Flag Bank

This block holds the single-bit interrupt controls and operating-mode controls of a small 4-bit processor core. The core reaches each bit through a nibble address and a 2-bit bit index. It issues one of three bit operations per cycle: set, reset or test. A test result is returned on a registered status output one cycle later. Each bit carries its own rule that decides whether a set, a reset or a test is carried out, dropped, or answered as invalid. One of those rules depends on whether the core runs in active or subactive mode.

Hardware event lines raise the six interrupt request flags on their rising edges. The block combines the global enable, the per-source masks and the request flags into a single interrupt request line. A reset of the stack-reset bit turns into a one-cycle clear pulse for the stack pointer. The four mode flags are exported as plain outputs for the clock, watchdog, tone and transfer logic nearby.

Top module: `irq_flag_bank`

## Requirements
- R1: After a synchronous active-low reset, every request flag, the global enable and the four mode flags read 0, every mask reads 1, and test_status, test_invalid, sp_clr and irq_req are 0.
- R2: op_code 2'b00 is no operation, 2'b01 set, 2'b10 reset, 2'b11 test. In the interrupt area (addresses 0 to 3) bit 3 of address 0 is the INT0 mask, bit 2 the INT0 flag, bit 1 the stack-reset bit and bit 0 the global enable. Address 1 holds timer A mask and flag in bits 3:2 and INT1 mask and flag in bits 1:0. Address 2 holds timer C mask and flag in bits 3:2 and timer B mask and flag in bits 1:0. Address 3 holds the serial mask in bit 1 and serial flag in bit 0. Masks and the enable follow set and reset from the next cycle. A test shows the bit's value on test_status in the cycle after the op, with test_invalid at 0. After any op other than a test, both test outputs are 0, and a no-op changes no bit.
- R3: A rising edge on evt_in[i] sets request flag i. The index order is INT0, INT1, timer A, timer B, timer C, serial. The flag is visible from the next cycle. A level held high does not set the flag again once it has been reset.
- R4: A set of any request flag is dropped. A reset clears it. When an event edge and a reset of the same flag arrive in the same cycle, the flag ends up set.
- R5: irq_req is high exactly when the global enable is 1 and some source has its flag at 1 and its mask at 0.
- R6: A set of the stack-reset bit is dropped. A reset of it drives sp_clr high for exactly the next cycle. A test of it is invalid.
- R7: The mode area is address 0x20: bit 0 low-speed-on (slow_clk_on), bit 1 watchdog-on, bit 2 tone-speed, bit 3 direct-transfer-on. Low-speed-on accepts set, reset and test.
- R8: Watchdog-on accepts set. A reset of it is dropped, and a test of it is invalid.
- R9: Tone-speed accepts set and reset. A test of it is invalid.
- R10: Direct-transfer-on is held at 0 in every cycle that follows a sampled sub_mode of 0. A set takes effect only while sub_mode is 1. Reset and test are allowed.
- R11: A test of an inhibited or unused bit sets test_status to 0 and pulses test_invalid for one cycle. Unused bits are address 3 bits 3:2, addresses 0x21 to 0x23 and every address outside both areas. Set or reset of an unused bit changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 2 | Bit operation: none, set, reset, test |
| op_addr | input | ADDR_W | Nibble address of the bit |
| op_bit | input | 2 | Bit index within the nibble |
| sub_mode | input | 1 | 1 while the core runs in subactive mode |
| evt_in | input | NUM_SRC | Interrupt event lines, rising-edge sensitive |
| test_status | output | 1 | Registered result of the last test |
| test_invalid | output | 1 | One-cycle pulse after a test of an inhibited or unused bit |
| irq_req | output | 1 | Combined interrupt request |
| sp_clr | output | 1 | One-cycle stack-pointer clear pulse |
| xfer_on | output | 1 | Direct-transfer-on mode flag |
| tone_fast | output | 1 | Tone-generator speed flag |
| wdog_on | output | 1 | Watchdog-on flag |
| slow_clk_on | output | 1 | Low-speed-on mode flag |

## Verification
The assertions assume that op_code, op_addr and op_bit hold steady around each rising clock edge. They also assume that an event line must be sampled low before a new edge can count. The stimulus meets both assumptions by changing every input only on the falling edge and by returning an event line to 0 before it raises that line again. The assertions make no assumption about which addresses are used. The stimulus therefore deliberately sends set, reset and test to unused and inhibited bits, and it toggles sub_mode between operations that touch the direct-transfer flag.

// File: rtl/irq_flag_pkg.sv
// Shared types for the interrupt control flag bank.
// Assumes at most 8 interrupt sources (3-bit source index).
package irq_flag_pkg;

    localparam int SRC_IDX_W = 3;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SET  = 2'b01,
        OP_CLR  = 2'b10,
        OP_TEST = 2'b11
    } flag_op_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_GIE,
        K_SPRST,
        K_MASK,
        K_REQ,
        K_XFER,
        K_TONE,
        K_WDOG,
        K_SLOW
    } bit_kind_e;

    typedef struct packed {
        bit_kind_e              kind;
        logic [SRC_IDX_W-1:0]   src;
    } bit_sel_t;

endpackage

// File: rtl/irq_bit_decode.sv
// Address decoder: maps a nibble address and bit index onto the kind of
// control bit it names and, for masks and request flags, the source index.
// Assumes the interrupt area starts at address 0 and packs two sources per
// nibble, with the global enable and stack-reset bit in the low half of 0.
module irq_bit_decode
    import irq_flag_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                NUM_SRC   = 6,
    parameter logic [ADDR_W-1:0] MODE_BASE = 'h20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bit_idx,
    output bit_sel_t          sel
);

    localparam int INT_DEPTH = (NUM_SRC + 2) / 2;

    // Classify the addressed bit.
    always_comb begin
        int src_i;
        sel.kind = K_NONE;
        sel.src  = '0;
        src_i    = 0;
        if (int'(addr) < INT_DEPTH) begin
            if ((addr == '0) && !bit_idx[1]) begin
                sel.kind = bit_idx[0] ? K_SPRST : K_GIE;
            end else begin
                src_i = 2 * int'(addr) + int'(bit_idx[1]) - 1;
                if (src_i < NUM_SRC) begin
                    sel.kind = bit_idx[0] ? K_MASK : K_REQ;
                    sel.src  = SRC_IDX_W'(src_i);
                end
            end
        end else if (addr == MODE_BASE) begin
            case (bit_idx)
                2'd0:    sel.kind = K_SLOW;
                2'd1:    sel.kind = K_WDOG;
                2'd2:    sel.kind = K_TONE;
                default: sel.kind = K_XFER;
            endcase
        end
    end

endmodule

// File: rtl/irq_src_bank.sv
// Per-source interrupt state: a request flag raised by a rising edge on its
// event line and cleared by a software reset (the edge wins a tie), plus a
// mask bit written by set and reset. Software set of a flag is dropped.
// Assumes event lines are synchronous to clk.
module irq_src_bank
    import irq_flag_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_in,
    input  flag_op_e           op,
    input  bit_sel_t           sel,
    output logic [NUM_SRC-1:0] req_q,
    output logic [NUM_SRC-1:0] mask_q
);

    logic [NUM_SRC-1:0] evt_d;

    // Delay the event lines by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_d <= '0;
        else        evt_d <= evt_in;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic hit;
        logic req_r;
        logic mask_r;

        assign hit = (sel.src == SRC_IDX_W'(i));

        // Request flag: event edge sets, software reset clears.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      req_r <= 1'b0;
            else if (evt_in[i] && !evt_d[i])                 req_r <= 1'b1;
            else if (op == OP_CLR && sel.kind == K_REQ && hit) req_r <= 1'b0;
        end

        // Mask bit: blocks its source while 1.
        always_ff @(posedge clk) begin
            if (!rst_n)                                        mask_r <= 1'b1;
            else if (op == OP_SET && sel.kind == K_MASK && hit) mask_r <= 1'b1;
            else if (op == OP_CLR && sel.kind == K_MASK && hit) mask_r <= 1'b0;
        end

        assign req_q[i]  = req_r;
        assign mask_q[i] = mask_r;
    end

endmodule

// File: rtl/irq_mode_regs.sv
// Operating-mode flags with their per-bit write rules: low-speed and tone
// follow set and reset, watchdog can only be set, and direct-transfer can
// be set only in subactive mode and is held cleared in active mode.
module irq_mode_regs
    import irq_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_op_e  op,
    input  bit_kind_e kind,
    input  logic      sub_mode,
    output logic      xfer_on,
    output logic      tone_fast,
    output logic      wdog_on,
    output logic      slow_clk_on
);

    // Direct-transfer flag: forced low outside subactive mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !sub_mode)                  xfer_on <= 1'b0;
        else if (op == OP_SET && kind == K_XFER)  xfer_on <= 1'b1;
        else if (op == OP_CLR && kind == K_XFER)  xfer_on <= 1'b0;
    end

    // Tone speed flag: plain set and reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                               tone_fast <= 1'b0;
        else if (op == OP_SET && kind == K_TONE)  tone_fast <= 1'b1;
        else if (op == OP_CLR && kind == K_TONE)  tone_fast <= 1'b0;
    end

    // Watchdog flag: set only, software cannot clear it.
    always_ff @(posedge clk) begin
        if (!rst_n)                               wdog_on <= 1'b0;
        else if (op == OP_SET && kind == K_WDOG)  wdog_on <= 1'b1;
    end

    // Low-speed flag: plain set and reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                               slow_clk_on <= 1'b0;
        else if (op == OP_SET && kind == K_SLOW)  slow_clk_on <= 1'b1;
        else if (op == OP_CLR && kind == K_SLOW)  slow_clk_on <= 1'b0;
    end

endmodule

// File: rtl/irq_flag_bank.sv
// Top of the interrupt control flag bank. Decodes one bit operation per
// cycle, applies each bit's own rule, returns registered test results with
// an invalid flag, combines enable, masks and flags into one request, and
// turns a reset of the stack-reset bit into a one-cycle clear pulse.
// Assumes inputs are synchronous to clk; NUM_SRC must not exceed 8.
module irq_flag_bank
    import irq_flag_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                NUM_SRC   = 6,
    parameter logic [ADDR_W-1:0] MODE_BASE = 'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         op_code,
    input  logic [ADDR_W-1:0]  op_addr,
    input  logic [1:0]         op_bit,
    input  logic               sub_mode,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic               test_status,
    output logic               test_invalid,
    output logic               irq_req,
    output logic               sp_clr,
    output logic               xfer_on,
    output logic               tone_fast,
    output logic               wdog_on,
    output logic               slow_clk_on
);

    flag_op_e           op;
    bit_sel_t           sel;
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               gie_q;
    logic               tval;
    logic               tok;

    assign op = flag_op_e'(op_code);

    irq_bit_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_SRC   (NUM_SRC),
        .MODE_BASE (MODE_BASE)
    ) u_dec (
        .addr    (op_addr),
        .bit_idx (op_bit),
        .sel     (sel)
    );

    irq_src_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .op     (op),
        .sel    (sel),
        .req_q  (req_q),
        .mask_q (mask_q)
    );

    irq_mode_regs u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .kind        (sel.kind),
        .sub_mode    (sub_mode),
        .xfer_on     (xfer_on),
        .tone_fast   (tone_fast),
        .wdog_on     (wdog_on),
        .slow_clk_on (slow_clk_on)
    );

    // Global interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  gie_q <= 1'b0;
        else if (op == OP_SET && sel.kind == K_GIE)  gie_q <= 1'b1;
        else if (op == OP_CLR && sel.kind == K_GIE)  gie_q <= 1'b0;
    end

    // Stack-pointer clear pulse on a reset of the stack-reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) sp_clr <= 1'b0;
        else        sp_clr <= (op == OP_CLR) && (sel.kind == K_SPRST);
    end

    // Select the testable value; inhibited and unused bits are not testable.
    always_comb begin
        tval = 1'b0;
        tok  = 1'b1;
        case (sel.kind)
            K_GIE:   tval = gie_q;
            K_MASK:  tval = mask_q[sel.src];
            K_REQ:   tval = req_q[sel.src];
            K_XFER:  tval = xfer_on;
            K_SLOW:  tval = slow_clk_on;
            default: tok  = 1'b0;
        endcase
    end

    // Register the test result and the invalid-test pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_status  <= 1'b0;
            test_invalid <= 1'b0;
        end else begin
            test_status  <= (op == OP_TEST) && tok && tval;
            test_invalid <= (op == OP_TEST) && !tok;
        end
    end

    // Combined request: enable AND any unmasked pending flag.
    assign irq_req = gie_q && |(req_q & ~mask_q);

endmodule

// File: rtl/irq_flag_bank_chk.sv
// Assertion checker for the interrupt control flag bank, bound to the top.
module irq_flag_bank_chk #(
    parameter int ADDR_W  = 6,
    parameter int NUM_SRC = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         op_code,
    input logic [ADDR_W-1:0]  op_addr,
    input logic [1:0]         op_bit,
    input logic               sub_mode,
    input logic [NUM_SRC-1:0] evt_in,
    input logic               test_status,
    input logic               test_invalid,
    input logic               sp_clr,
    input logic               wdog_on,
    input logic               xfer_on,
    input logic [NUM_SRC-1:0] req_q
);

    AST_FLAG_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_q & ~$past(req_q)) & ~$past(evt_in)) == '0); // R3

    AST_INVALID_AFTER_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        test_invalid |-> $past(op_code) == 2'b11); // R2

    AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        test_invalid |-> !test_status); // R11

    AST_SP_CLR_FROM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        sp_clr |-> ($past(op_code) == 2'b10 && $past(op_addr) == '0 && $past(op_bit) == 2'd1)); // R6

    AST_WDOG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_on |=> wdog_on); // R8

    AST_XFER_ACTIVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_mode |=> !xfer_on); // R10

endmodule

bind irq_flag_bank irq_flag_bank_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_code      (op_code),
    .op_addr      (op_addr),
    .op_bit       (op_bit),
    .sub_mode     (sub_mode),
    .evt_in       (evt_in),
    .test_status  (test_status),
    .test_invalid (test_invalid),
    .sp_clr       (sp_clr),
    .wdog_on      (wdog_on),
    .xfer_on      (xfer_on),
    .req_q        (req_q)
);

// File: tb/irq_flag_bank_tb.sv
module irq_flag_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 32;

    // Vector: {op[16:15], addr[14:9], bit[8:7], sub[6], exp_status[5], exp_invalid[4], req[3:0]}
    localparam logic [16:0] VEC [NV] = '{
        {2'b11, 6'h00, 2'd0, 1'b0, 1'b0, 1'b0, 4'd1},   // R1 enable reads 0
        {2'b11, 6'h00, 2'd3, 1'b0, 1'b1, 1'b0, 4'd1},   // R1 INT0 mask reads 1
        {2'b01, 6'h00, 2'd0, 1'b0, 1'b0, 1'b0, 4'd2},   // R2 set enable
        {2'b11, 6'h00, 2'd0, 1'b0, 1'b1, 1'b0, 4'd2},
        {2'b10, 6'h00, 2'd3, 1'b0, 1'b0, 1'b0, 4'd2},   // R2 reset INT0 mask
        {2'b11, 6'h00, 2'd3, 1'b0, 1'b0, 1'b0, 4'd2},
        {2'b11, 6'h01, 2'd1, 1'b0, 1'b1, 1'b0, 4'd2},   // R2 INT1 mask
        {2'b01, 6'h00, 2'd2, 1'b0, 1'b0, 1'b0, 4'd4},   // R4 software set of flag
        {2'b11, 6'h00, 2'd2, 1'b0, 1'b0, 1'b0, 4'd4},
        {2'b01, 6'h00, 2'd1, 1'b0, 1'b0, 1'b0, 4'd6},   // R6 set stack-reset bit
        {2'b11, 6'h00, 2'd1, 1'b0, 1'b0, 1'b1, 4'd6},
        {2'b01, 6'h03, 2'd3, 1'b0, 1'b0, 1'b0, 4'd11},  // R11 unused bits
        {2'b11, 6'h03, 2'd3, 1'b0, 1'b0, 1'b1, 4'd11},
        {2'b11, 6'h03, 2'd2, 1'b0, 1'b0, 1'b1, 4'd11},
        {2'b11, 6'h21, 2'd0, 1'b0, 1'b0, 1'b1, 4'd11},
        {2'b11, 6'h10, 2'd0, 1'b0, 1'b0, 1'b1, 4'd11},
        {2'b01, 6'h20, 2'd0, 1'b0, 1'b0, 1'b0, 4'd7},   // R7 low-speed
        {2'b11, 6'h20, 2'd0, 1'b0, 1'b1, 1'b0, 4'd7},
        {2'b10, 6'h20, 2'd0, 1'b0, 1'b0, 1'b0, 4'd7},
        {2'b11, 6'h20, 2'd0, 1'b0, 1'b0, 1'b0, 4'd7},
        {2'b01, 6'h20, 2'd1, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 watchdog
        {2'b10, 6'h20, 2'd1, 1'b0, 1'b0, 1'b0, 4'd8},
        {2'b11, 6'h20, 2'd1, 1'b0, 1'b0, 1'b1, 4'd8},
        {2'b01, 6'h20, 2'd2, 1'b0, 1'b0, 1'b0, 4'd9},   // R9 tone
        {2'b11, 6'h20, 2'd2, 1'b0, 1'b0, 1'b1, 4'd9},
        {2'b01, 6'h20, 2'd3, 1'b0, 1'b0, 1'b0, 4'd10},  // R10 set in active mode
        {2'b11, 6'h20, 2'd3, 1'b0, 1'b0, 1'b0, 4'd10},
        {2'b01, 6'h20, 2'd3, 1'b1, 1'b0, 1'b0, 4'd10},  // R10 set in subactive
        {2'b11, 6'h20, 2'd3, 1'b1, 1'b1, 1'b0, 4'd10},
        {2'b00, 6'h20, 2'd3, 1'b0, 1'b0, 1'b0, 4'd10},  // back to active
        {2'b11, 6'h20, 2'd3, 1'b0, 1'b0, 1'b0, 4'd10},
        {2'b11, 6'h03, 2'd1, 1'b0, 1'b1, 1'b0, 4'd2}    // R2 serial mask
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] op_code;
    logic [5:0] op_addr;
    logic [1:0] op_bit;
    logic       sub_mode;
    logic [5:0] evt_in;
    logic       test_status, test_invalid, irq_req, sp_clr;
    logic       xfer_on, tone_fast, wdog_on, slow_clk_on;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_flag_bank u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_code      (op_code),
        .op_addr      (op_addr),
        .op_bit       (op_bit),
        .sub_mode     (sub_mode),
        .evt_in       (evt_in),
        .test_status  (test_status),
        .test_invalid (test_invalid),
        .irq_req      (irq_req),
        .sp_clr       (sp_clr),
        .xfer_on      (xfer_on),
        .tone_fast    (tone_fast),
        .wdog_on      (wdog_on),
        .slow_clk_on  (slow_clk_on)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // Drive one op for one edge, then return to no-op; ends on a falling edge.
    task automatic apply(input logic [1:0] c, input logic [5:0] a,
                         input logic [1:0] b, input logic s);
        @(negedge clk);
        op_code = c; op_addr = a; op_bit = b; sub_mode = s;
        @(negedge clk);
        op_code = 2'b00;
    endtask

    task automatic test_bit(input string tag, input logic [5:0] a,
                            input logic [1:0] b, input logic exp);
        apply(2'b11, a, b, sub_mode);
        check(tag, test_status, exp);
        check(tag, test_invalid, 1'b0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_code = 2'b00; op_addr = '0; op_bit = '0;
        sub_mode = 1'b0; evt_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq_req", irq_req, 1'b0);
        check("R1 sp_clr", sp_clr, 1'b0);
        check("R1 wdog_on", wdog_on, 1'b0);

        // Vector table walk.
        for (int k = 0; k < NV; k++) begin
            logic [16:0] v;
            v = VEC[k];
            apply(v[16:15], v[14:9], v[8:7], v[6]);
            check($sformatf("R%0d status v%0d", v[3:0], k), test_status, v[5]);
            check($sformatf("R%0d invalid v%0d", v[3:0], k), test_invalid, v[4]);
        end

        // R11: invalid pulse lasts one cycle.
        apply(2'b11, 6'h22, 2'd1, 1'b0);
        check("R11 invalid pulse", test_invalid, 1'b1);
        @(negedge clk);
        check("R11 invalid drops", test_invalid, 1'b0);

        // R8, R9: mode outputs at the ports.
        check("R8 wdog held after reset op", wdog_on, 1'b1);
        check("R9 tone set", tone_fast, 1'b1);
        apply(2'b10, 6'h20, 2'd2, 1'b0);
        check("R9 tone reset", tone_fast, 1'b0);

        // R3: rising edge sets INT0 flag; enable 1, INT0 mask 0.
        check("R5 idle", irq_req, 1'b0);
        @(negedge clk); evt_in[0] = 1'b1;
        @(negedge clk);
        check("R3 edge raises irq", irq_req, 1'b1);
        test_bit("R3 flag set", 6'h00, 2'd2, 1'b1);
        apply(2'b10, 6'h00, 2'd2, 1'b0);
        test_bit("R3 level no re-set", 6'h00, 2'd2, 1'b0);

        // R4: event edge and reset together, edge wins.
        @(negedge clk); evt_in[0] = 1'b0;
        @(negedge clk);
        evt_in[0] = 1'b1; op_code = 2'b10; op_addr = 6'h00; op_bit = 2'd2;
        @(negedge clk); op_code = 2'b00;
        test_bit("R4 edge beats reset", 6'h00, 2'd2, 1'b1);

        // R5: enable and masks.
        check("R5 pending", irq_req, 1'b1);
        apply(2'b10, 6'h00, 2'd0, 1'b0);
        check("R5 enable off", irq_req, 1'b0);
        apply(2'b01, 6'h00, 2'd0, 1'b0);
        check("R5 enable on", irq_req, 1'b1);
        apply(2'b01, 6'h00, 2'd3, 1'b0);
        check("R5 masked", irq_req, 1'b0);
        @(negedge clk); evt_in[5] = 1'b1;
        @(negedge clk);
        check("R5 serial masked", irq_req, 1'b0);
        apply(2'b10, 6'h03, 2'd1, 1'b0);
        check("R5 serial unmasked", irq_req, 1'b1);
        apply(2'b10, 6'h03, 2'd0, 1'b0);
        check("R4 serial flag reset", irq_req, 1'b0);

        // R6: stack-pointer clear pulse.
        apply(2'b01, 6'h00, 2'd1, 1'b0);
        check("R6 set no pulse", sp_clr, 1'b0);
        apply(2'b10, 6'h00, 2'd1, 1'b0);
        check("R6 pulse", sp_clr, 1'b1);
        @(negedge clk);
        check("R6 pulse ends", sp_clr, 1'b0);

        // R10: direct-transfer flag at the port.
        apply(2'b01, 6'h20, 2'd3, 1'b1);
        check("R10 set subactive", xfer_on, 1'b1);
        apply(2'b00, 6'h00, 2'd0, 1'b0);
        check("R10 cleared in active", xfer_on, 1'b0);

        // R1: reset mid-run.
        @(negedge clk); rst_n = 1'b0; evt_in = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 wdog_on", wdog_on, 1'b0);
        check("R1 slow_clk_on", slow_clk_on, 1'b0);
        check("R1 tone_fast", tone_fast, 1'b0);
        check("R1 test_status", test_status, 1'b0);
        test_bit("R1 INT0 mask", 6'h00, 2'd3, 1'b1);
        test_bit("R1 enable", 6'h00, 2'd0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule